// File: doc/BRIEF.md
# Serial Mode Register File

This block receives one-byte configuration writes over a three-wire serial port (clock, data, active-low select) and holds the mode fields used by a display timing generator. Every byte is sent least significant bit first. The high nibble selects one of twelve nibble slots. The low nibble carries four data bits, which land in that slot.

The slots are grouped into six fields:

- an 11-bit clock divider setting;
- a 7-bit horizontal start position;
- a 7-bit vertical start position;
- a 4-bit sample-and-hold phase;
- a 2-bit clamp position;
- a 12-bit general-purpose output word that drives pins directly.

All three serial inputs are resynchronised to the system clock, and edges are detected in that domain. The serial clock must therefore be several times slower than the system clock. A byte changes a field only when the select line returns high. An active-low asynchronous clear zeroes every field.

Top module: `ser_mode_cfg`

## Requirements
- R1: Data bits are captured on rising edges of `sck_i` while `csn_i` is low. The first captured bit is byte bit 0 and the eighth is byte bit 7. Bits 7:4 form the slot address and bits 3:0 form the data nibble.
- R2: No output changes while a byte is being shifted in. A complete byte takes effect only after `csn_i` goes from low to high.
- R3: Slots 0, 1 and 2 load `div_o` bits 3:0, 7:4 and 10:8. At slot 2, data bit 3 is dropped.
- R4: Slots 3 and 4 load `hpos_o` bits 3:0 and 6:4. Slots 5 and 6 load `vpos_o` bits 3:0 and 6:4. Data bit 3 is dropped at slots 4 and 6.
- R5: Slot 7 loads `shp_o` bits 3:0. Slot 8 loads `clamp_o` from data bits 1:0, and its data bits 3:2 are dropped.
- R6: Slots 9, 10 and 11 load `gpo_o` bits 3:0, 7:4 and 11:8.
- R7: Bytes addressed to slots 12 to 15 change no output.
- R8: A select rise after fewer than eight rising `sck_i` edges changes nothing. Rising edges beyond the eighth are discarded, and the first eight bits are used.
- R9: `rst_ni` low clears every output bit to 0 at once, without waiting for a clock edge.
- R10: Rising `sck_i` edges while `csn_i` is high shift nothing and do not count toward the next byte.
- R11: A write changes only the bits its slot maps to. All other output bits keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low clear |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data |
| csn_i | input | 1 | Serial select, active low |
| div_o | output | 11 | Clock divider setting |
| hpos_o | output | 7 | Horizontal start position |
| vpos_o | output | 7 | Vertical start position |
| shp_o | output | 4 | Sample-and-hold phase |
| clamp_o | output | 2 | Clamp position |
| gpo_o | output | 12 | General-purpose output word |

## Verification
The bench looks for a reversed bit order. Such a design would put the address in the data nibble, and fields would fill with the wrong values.

It sends truncated and over-long frames:
- A design that commits short frames would corrupt slots.
- A design that keeps shifting past eight bits would commit the trailing bits instead of the first byte.

It also targets:
- writes to slots 12 to 15, which a loose decoder would alias onto real slots;
- writes with the dropped data bits set, where a missing mask would leak a stray bit into a field;
- clock pulses sent while the select line is high, which a design without gating would shift in.

Outputs are sampled between the last clock and the select rise, so a design that commits early is caught. An asynchronous clear in mid-run, checked before any clock edge, exposes a reset that is only synchronous.

// File: rtl/ser_mode_pkg.sv
package ser_mode_pkg;
  localparam int FRAME_W  = 8;
  localparam int NIB_W    = 4;
  localparam int ADDR_W   = FRAME_W - NIB_W;
  localparam int NUM_SLOT = 12;
  localparam int BANK_W   = NUM_SLOT * NIB_W;

  localparam int DIV_W = 11;
  localparam int POS_W = 7;
  localparam int SHP_W = 4;
  localparam int CLP_W = 2;
  localparam int GPO_W = 12;

  typedef enum logic [ADDR_W-1:0] {
    SLOT_DIV0 = 4'h0, SLOT_DIV1 = 4'h1, SLOT_DIV2 = 4'h2,
    SLOT_HP0  = 4'h3, SLOT_HP1  = 4'h4,
    SLOT_VP0  = 4'h5, SLOT_VP1  = 4'h6,
    SLOT_SHP  = 4'h7, SLOT_CLP  = 4'h8,
    SLOT_GPO0 = 4'h9, SLOT_GPO1 = 4'hA, SLOT_GPO2 = 4'hB
  } slot_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [NIB_W-1:0]  data;
  } frame_t;

  // bits of each slot that carry state
  function automatic logic [NIB_W-1:0] slot_mask(input int unsigned idx);
    case (idx)
      SLOT_DIV2, SLOT_HP1, SLOT_VP1: slot_mask = 4'h7;
      SLOT_CLP:                      slot_mask = 4'h3;
      default:                       slot_mask = (idx < NUM_SLOT) ? 4'hF : 4'h0;
    endcase
  endfunction
endpackage

// File: rtl/ser_mode_sync.sv
module ser_mode_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ser_mode_rx.sv
module ser_mode_rx
  import ser_mode_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_s_i,
  input  logic               sdi_s_i,
  input  logic               csn_s_i,
  output logic               vld_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic               sck_q, csn_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] shift_q;
  logic               sck_rise, cs_rise, full;

  assign sck_rise = sck_s_i & ~sck_q;
  assign cs_rise  = csn_s_i & ~csn_q;
  assign full     = (cnt_q == CNT_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      csn_q <= 1'b1;
    end else begin
      sck_q <= sck_s_i;
      csn_q <= csn_s_i;
    end
  end

  // LSB first: first bit ends in position 0 after FRAME_W shifts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (csn_s_i) begin
      cnt_q <= '0;
    end else if (sck_rise && !full) begin
      cnt_q   <= cnt_q + 1'b1;
      shift_q <= {sdi_s_i, shift_q[FRAME_W-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      frame_o <= '0;
    end else begin
      vld_o <= cs_rise && full;
      if (cs_rise && full) frame_o <= shift_q;
    end
  end
endmodule

// File: rtl/ser_mode_bank.sv
module ser_mode_bank
  import ser_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [NIB_W-1:0]  wr_data_i,
  output logic [BANK_W-1:0] bank_o
);
  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
    localparam logic [NIB_W-1:0] MASK = slot_mask(i);
    logic [NIB_W-1:0] nib_q;
    logic             hit;

    assign hit = wr_en_i && (wr_addr_i == ADDR_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  nib_q <= '0;
      else if (hit) nib_q <= wr_data_i & MASK;
    end

    assign bank_o[i*NIB_W +: NIB_W] = nib_q;
  end
endmodule

// File: rtl/ser_mode_cfg.sv
module ser_mode_cfg
  import ser_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             sdi_i,
  input  logic             csn_i,
  output logic [DIV_W-1:0] div_o,
  output logic [POS_W-1:0] hpos_o,
  output logic [POS_W-1:0] vpos_o,
  output logic [SHP_W-1:0] shp_o,
  output logic [CLP_W-1:0] clamp_o,
  output logic [GPO_W-1:0] gpo_o
);
  logic              sck_s, sdi_s, csn_s;
  logic              wr_en;
  frame_t            frame;
  logic [ADDR_W-1:0] wr_addr;
  logic [NIB_W-1:0]  wr_data;
  logic [BANK_W-1:0] bank;

  ser_mode_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_d (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, sdi_i}),
    .q_o   ({sck_s, sdi_s})
  );

  ser_mode_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (csn_i),
    .q_o   (csn_s)
  );

  ser_mode_rx u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_s_i(sck_s),
    .sdi_s_i(sdi_s),
    .csn_s_i(csn_s),
    .vld_o  (wr_en),
    .frame_o(frame)
  );

  assign wr_addr = frame.addr;
  assign wr_data = frame.data;

  ser_mode_bank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .bank_o   (bank)
  );

  function automatic logic [NIB_W-1:0] nib(input int unsigned idx);
    nib = bank[idx*NIB_W +: NIB_W];
  endfunction

  assign div_o   = {nib(SLOT_DIV2) [2:0], nib(SLOT_DIV1), nib(SLOT_DIV0)};
  assign hpos_o  = {nib(SLOT_HP1)  [2:0], nib(SLOT_HP0)};
  assign vpos_o  = {nib(SLOT_VP1)  [2:0], nib(SLOT_VP0)};
  assign shp_o   = nib(SLOT_SHP);
  assign clamp_o = nib(SLOT_CLP) [1:0];
  assign gpo_o   = {nib(SLOT_GPO2), nib(SLOT_GPO1), nib(SLOT_GPO0)};
endmodule

// File: rtl/ser_mode_cfg_chk.sv
module ser_mode_cfg_chk
  import ser_mode_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             csn_s,
  input logic             wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [NIB_W-1:0] wr_data,
  input logic [DIV_W-1:0] div_o,
  input logic [POS_W-1:0] hpos_o,
  input logic [POS_W-1:0] vpos_o,
  input logic [SHP_W-1:0] shp_o,
  input logic [CLP_W-1:0] clamp_o,
  input logic [GPO_W-1:0] gpo_o
);
  logic [DIV_W+2*POS_W+SHP_W+CLP_W+GPO_W-1:0] all_f;
  assign all_f = {div_o, hpos_o, vpos_o, shp_o, clamp_o, gpo_o};

  p_commit_cs_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> csn_s);

  p_hold_no_commit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(all_f));

  p_high_slot_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr >= ADDR_W'(NUM_SLOT)) |=> $stable(all_f));

  p_div_top_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr == SLOT_DIV2) |=> div_o[10:8] == $past(wr_data[2:0]));

  p_clamp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr == SLOT_CLP) |=> (clamp_o == $past(wr_data[1:0])) && $stable(gpo_o));

  p_gpo_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr == SLOT_GPO0) |=> (gpo_o[3:0] == $past(wr_data)) && $stable(div_o));
endmodule

bind ser_mode_cfg ser_mode_cfg_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .csn_s  (csn_s),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .wr_data(wr_data),
  .div_o  (div_o),
  .hpos_o (hpos_o),
  .vpos_o (vpos_o),
  .shp_o  (shp_o),
  .clamp_o(clamp_o),
  .gpo_o  (gpo_o)
);

// File: tb/ser_mode_cfg_tb.sv
module ser_mode_cfg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, sdi = 1'b0, csn = 1'b1;
  logic [10:0] div;
  logic [6:0]  hpos, vpos;
  logic [3:0]  shp;
  logic [1:0]  clamp;
  logic [11:0] gpo;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [3:0] exp_nib [12];

  always #10 clk = ~clk;

  ser_mode_cfg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .sdi_i(sdi), .csn_i(csn),
    .div_o(div), .hpos_o(hpos), .vpos_o(vpos), .shp_o(shp),
    .clamp_o(clamp), .gpo_o(gpo)
  );

  function automatic logic [3:0] keep_bits(input int a);
    if (a == 2 || a == 4 || a == 6) return 4'h7;   // R3 R4
    if (a == 8) return 4'h3;                        // R5
    return 4'hF;
  endfunction

  task automatic chk_val(input string tag, input string nm, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk_val(tag, "div",   12'(div),   12'({exp_nib[2][2:0], exp_nib[1], exp_nib[0]}));
    chk_val(tag, "hpos",  12'(hpos),  12'({exp_nib[4][2:0], exp_nib[3]}));
    chk_val(tag, "vpos",  12'(vpos),  12'({exp_nib[6][2:0], exp_nib[5]}));
    chk_val(tag, "shp",   12'(shp),   12'(exp_nib[7]));
    chk_val(tag, "clamp", 12'(clamp), 12'(exp_nib[8][1:0]));
    chk_val(tag, "gpo",   gpo,        {exp_nib[11], exp_nib[10], exp_nib[9]});
  endtask

  task automatic model_clear();
    for (int i = 0; i < 12; i++) exp_nib[i] = 4'h0;
  endtask

  // nbits rising SCK edges; bits past 8 come from extra
  task automatic send_frame(input logic [7:0] b, input int nbits, input logic [3:0] extra, input string tag);
    @(negedge clk); csn = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 8) ? b[i] : extra[(i - 8) % 4];
      repeat (3) @(negedge clk); sck = 1'b1;
      repeat (3) @(negedge clk); sck = 1'b0;
    end
    repeat (6) @(negedge clk);
    chk_all({tag, " R2 pre-commit"});
    csn = 1'b1;
    repeat (8) @(negedge clk);
    if (nbits >= 8 && b[7:4] < 4'd12)
      exp_nib[b[7:4]] = b[3:0] & keep_bits(int'(b[7:4]));
    chk_all(tag);
  endtask

  initial begin
    model_clear();
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk_all("R9 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    send_frame(8'hB5, 8, 4'h0, "R1 R6 gpo hi");
    send_frame(8'h31, 8, 4'h0, "R1 R4 hpos lo");
    send_frame(8'h2F, 8, 4'h0, "R3 div top mask");
    send_frame(8'h0E, 8, 4'h0, "R3 div lo");
    send_frame(8'h4F, 8, 4'h0, "R4 hpos mask");
    send_frame(8'h6F, 8, 4'h0, "R4 vpos mask");
    send_frame(8'h7C, 8, 4'h0, "R5 shp");
    send_frame(8'h8F, 8, 4'h0, "R5 clamp mask");
    send_frame(8'hC5, 8, 4'h0, "R7 slot C");
    send_frame(8'hFF, 8, 4'h0, "R7 slot F");
    send_frame(8'h95, 7, 4'h0, "R8 short");
    send_frame(8'h9A, 10, 4'hF, "R8 long");
    send_frame(8'hA3, 8, 4'h0, "R11 gpo mid");

    // R10: SCK pulses with CS high, then a normal frame
    sdi = 1'b1;
    for (int i = 0; i < 5; i++) begin
      repeat (3) @(negedge clk); sck = 1'b1;
      repeat (3) @(negedge clk); sck = 1'b0;
    end
    send_frame(8'h10, 8, 4'h0, "R10 sck idle");

    for (int k = 0; k < 150; k++) begin
      logic [7:0] b;
      int r, n;
      b = 8'($urandom);
      r = int'($urandom % 10);
      n = (r == 0) ? 5 : (r == 1) ? 10 : 8;
      send_frame(b, n, 4'($urandom), "R11 random");
    end

    // R9: async clear without a clock edge
    @(negedge clk); rst_n = 1'b0;
    #3;
    model_clear();
    chk_all("R9 async clear");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    send_frame(8'h86, 8, 4'h0, "R9 after clear");

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule